// File: doc/BRIEF.md
# Load-Use Stall and Branch Squash Control

This block decides, every cycle, whether the front of a five-stage in-order pipeline may advance. It watches the instruction sitting in the execute-bound pipeline register and the one sitting in the decode register. When the execute-bound instruction is a load and its destination register is named by either source operand of the decode instruction, the operand cannot be supplied in time. The block then freezes the program counter and the decode register for one cycle and turns the execute-bound slot into a no-op. After that single cycle the load's result can reach the dependent instruction through the late forwarding path.

Branches in this pipeline are compared and their targets computed in decode. A taken branch therefore has fetched exactly one wrong instruction. The block clears that instruction out of the decode register before it can write any register or memory. A stall outranks a branch in the same cycle: the squash is withheld, and the branch, still held in decode, is evaluated again on the next cycle.

The logic is purely combinational. The clock and reset serve only the embedded checks. Register number width and operand count are parameters.

Top module: `hazard_ctrl`

## Requirements
- R1: With `ld_flag_i`=1 and `ld_dst_i` equal to source field 0 (bits [REG_AW-1:0] of `dec_src_i`), `idex_bubble_o`=1 in the same cycle.
- R2: With `ld_flag_i`=1 and `ld_dst_i` equal to source field 1 (bits [2*REG_AW-1:REG_AW] of `dec_src_i`), `idex_bubble_o`=1 in the same cycle.
- R3: With `ld_flag_i`=0, no stall occurs whatever the register numbers are, because only loads set that flag.
- R4: While a stall is raised, `pc_we_o`=0 and `ifid_we_o`=0, so the decode instruction repeats its decode stage.
- R5: `idex_bubble_o` is 1 exactly in the cycles in which a stall is raised, zeroing every control bit entering the execute register.
- R6: With `br_taken_i`=1 and no stall, `ifid_flush_o`=1, while `pc_we_o`=1 and `ifid_we_o`=1 so that the target is fetched.
- R7: With a stall and `br_taken_i`=1 in the same cycle, `ifid_flush_o`=0. The branch is squashed on the first later cycle without a stall in which it is still taken.
- R8: With no load match and `br_taken_i`=0, `pc_we_o`=1, `ifid_we_o`=1, `idex_bubble_o`=0 and `ifid_flush_o`=0.
- R9: A stall lasts one cycle. Once the bubble occupies the execute register (`ld_flag_i`=0), both enables return to 1 with the same decode contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the embedded checks |
| rst_ni | input | 1 | Active-low asynchronous reset for the embedded checks |
| ld_flag_i | input | 1 | Execute-bound instruction reads memory (a load) |
| ld_dst_i | input | REG_AW | Destination register of the execute-bound instruction |
| dec_src_i | input | NUM_SRC*REG_AW | Source register fields of the decode instruction, field 0 lowest |
| br_taken_i | input | 1 | Branch in decode resolved taken |
| pc_we_o | output | 1 | Program counter write enable |
| ifid_we_o | output | 1 | Decode register write enable |
| idex_bubble_o | output | 1 | Zero the control bits entering the execute register |
| ifid_flush_o | output | 1 | Clear the decode register (squash) |

## Verification
The embedded checks hold on every cycle. They check that a stall always drops both enables together with the bubble, that a squash never coincides with a stall or a frozen front end, that a stall never arises without the load flag, and that a register match under the load flag always stalls. Some behaviour lies in the order of events and only the bench's scenarios can show it: the single-cycle length of a stall once the bubble reaches execute, and a branch that is held back by a stall and then squashed a cycle later. The bench also sweeps every input combination of a 3-bit register configuration against arithmetically computed enables.

// File: rtl/hz_pkg.sv
package hz_pkg;
  localparam int unsigned REG_AW_DEF  = 5;
  localparam int unsigned NUM_SRC_DEF = 2;

  typedef struct packed {
    logic pc_we;
    logic ifid_we;
    logic bubble;
    logic flush;
  } hz_ctrl_t;
endpackage

// File: rtl/hz_load_use_det.sv
module hz_load_use_det #(
  parameter int unsigned REG_AW  = hz_pkg::REG_AW_DEF,
  parameter int unsigned NUM_SRC = hz_pkg::NUM_SRC_DEF,
  localparam int unsigned SRC_W  = REG_AW * NUM_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_flag_i,
  input  logic [REG_AW-1:0] ld_dst_i,
  input  logic [SRC_W-1:0]  dec_src_i,
  output logic              stall_o
);
  logic [NUM_SRC-1:0] hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign hit[g] = (dec_src_i[g*REG_AW +: REG_AW] == ld_dst_i);
  end

  assign stall_o = ld_flag_i & (|hit);

  assert_no_stall_wo_load_R3 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ld_flag_i);
  assert_src0_match_R1 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_flag_i && dec_src_i[REG_AW-1:0] == ld_dst_i) |-> stall_o);
  assert_src1_match_R2 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_flag_i && dec_src_i[SRC_W-1 -: REG_AW] == ld_dst_i) |-> stall_o);
endmodule

// File: rtl/hz_squash.sv
module hz_squash (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic br_taken_i,
  input  logic stall_i,
  output logic flush_o
);
  // stall wins; branch stays in decode and is re-evaluated next cycle
  assign flush_o = br_taken_i & ~stall_i;

  assert_no_flush_in_stall_R7 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |-> !flush_o);
  assert_flush_on_taken_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_taken_i && !stall_i) |-> flush_o);
endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl #(
  parameter int unsigned REG_AW  = hz_pkg::REG_AW_DEF,
  parameter int unsigned NUM_SRC = hz_pkg::NUM_SRC_DEF,
  localparam int unsigned SRC_W  = REG_AW * NUM_SRC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_flag_i,
  input  logic [REG_AW-1:0] ld_dst_i,
  input  logic [SRC_W-1:0]  dec_src_i,
  input  logic              br_taken_i,
  output logic              pc_we_o,
  output logic              ifid_we_o,
  output logic              idex_bubble_o,
  output logic              ifid_flush_o
);
  import hz_pkg::*;

  logic     stall;
  logic     flush;
  hz_ctrl_t ctrl;

  hz_load_use_det #(
    .REG_AW  (REG_AW),
    .NUM_SRC (NUM_SRC)
  ) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ld_flag_i (ld_flag_i),
    .ld_dst_i  (ld_dst_i),
    .dec_src_i (dec_src_i),
    .stall_o   (stall)
  );

  hz_squash u_sq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .br_taken_i (br_taken_i),
    .stall_i    (stall),
    .flush_o    (flush)
  );

  always_comb begin
    ctrl.pc_we   = ~stall;
    ctrl.ifid_we = ~stall;
    ctrl.bubble  = stall;
    ctrl.flush   = flush;
  end

  assign pc_we_o       = ctrl.pc_we;
  assign ifid_we_o     = ctrl.ifid_we;
  assign idex_bubble_o = ctrl.bubble;
  assign ifid_flush_o  = ctrl.flush;

  assert_freeze_both_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    idex_bubble_o |-> (!pc_we_o && !ifid_we_o));
  assert_bubble_excl_flush_R5 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({idex_bubble_o, ifid_flush_o}));
  assert_flush_advances_R6 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ifid_flush_o |-> (pc_we_o && ifid_we_o));
  assert_enables_agree_R4 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o == ifid_we_o);
  assert_idle_R8 : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_flag_i && !br_taken_i) |-> (pc_we_o && !idex_bubble_o && !ifid_flush_o));
endmodule

// File: tb/sim_hazard_ctrl.sv
`timescale 1ns/1ps
module sim_hazard_ctrl;
  localparam int AW = 3;
  localparam int NS = 2;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          ld_flag_i = 1'b0;
  logic [AW-1:0] ld_dst_i = '0;
  logic [2*AW-1:0] dec_src_i = '0;
  logic          br_taken_i = 1'b0;
  logic          pc_we_o, ifid_we_o, idex_bubble_o, ifid_flush_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk_i = ~clk_i;

  hazard_ctrl #(.REG_AW(AW), .NUM_SRC(NS)) u0 (
    .clk_i, .rst_ni, .ld_flag_i, .ld_dst_i, .dec_src_i, .br_taken_i,
    .pc_we_o, .ifid_we_o, .idex_bubble_o, .ifid_flush_o
  );

  // packed {pc_we, ifid_we, bubble, flush}
  task automatic check(input string tag, input logic [3:0] exp);
    logic [3:0] got;
    got = {pc_we_o, ifid_we_o, idex_bubble_o, ifid_flush_o};
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b (ld=%b dst=%0d src=%h br=%b)",
               tag, got, exp, ld_flag_i, ld_dst_i, dec_src_i, br_taken_i);
    end
  endtask

  task automatic drive(input logic ld, input int dst, input int s0, input int s1,
                       input logic br);
    @(negedge clk_i);
    ld_flag_i  = ld;
    ld_dst_i   = AW'(dst);
    dec_src_i  = {AW'(s1), AW'(s0)};
    br_taken_i = br;
    #1;
  endtask

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    // reset state: quiet inputs give free-running front end (R8)
    #1;
    check("R8 reset", 4'b1100);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // exhaustive sweep
    for (int ld = 0; ld < 2; ld++)
      for (int d = 0; d < (1 << AW); d++)
        for (int s0 = 0; s0 < (1 << AW); s0++)
          for (int s1 = 0; s1 < (1 << AW); s1++)
            for (int br = 0; br < 2; br++) begin
              logic st, fl;
              logic [3:0] e;
              string tag;
              drive(ld[0], d, s0, s1, br[0]);
              st = (ld == 1) && (d == s0 || d == s1);
              fl = (br == 1) && !st;
              e  = {!st, !st, st, fl};
              if (st && br == 1)      tag = "R7 R4 R5";
              else if (st && d == s0) tag = "R1 R4 R5";
              else if (st)            tag = "R2 R4 R5";
              else if (ld == 0 && (d == s0 || d == s1)) tag = br ? "R3 R6" : "R3";
              else if (br == 1)       tag = "R6";
              else                    tag = "R8";
              check(tag, e);
            end

    // R9: load r5 then dependent; bubble reaches execute, stall clears
    drive(1'b1, 5, 5, 2, 1'b0);
    check("R9 stall cycle", 4'b0010);
    drive(1'b0, 0, 5, 2, 1'b0);
    check("R9 resume", 4'b1100);

    // R7: stall and branch together, branch squashes on the next cycle
    drive(1'b1, 3, 1, 3, 1'b1);
    check("R7 held", 4'b0010);
    drive(1'b0, 0, 1, 3, 1'b1);
    check("R7 re-eval", 4'b1101);
    drive(1'b0, 0, 0, 0, 1'b0);
    check("R8 after", 4'b1100);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule